// File: doc/BRIEF.md
# Gold-Code Chip and Frame Timing Generator

This block drives the digital side of a four-channel compressive sampler. Each master clock cycle it delivers one pseudo-random chip per channel; downstream mixers read each chip as a +1 or -1 multiplier. It also produces all the frame timing that the analog channels need. Two 6-bit linear-feedback shift registers run in lock step. The first is cut short to a 52-state cycle, so it also acts as the frame divider. The second runs its full 63-state cycle. For each channel, the output bit of the short register is XORed with a different bit of the long register. This gives four distinct Gold-code sequences, each 3276 chips long.

The frame is 52 cycles long. Each channel's track-and-hold strobe falls at its own point in the frame, 13 cycles apart from the next channel's. Each channel's integrator select level flips after its own strobe, so two integrating capacitors can take turns. The block retimes the long register's wrap pulse with the short register's wrap pulse to form a sync output. Sync stays high for one whole frame, once per full code period. It marks where the chipping sequence starts, and later recovery steps depend on that mark. The block has no data stream: every pin is a plain level. If a register ever reaches the all-zero state, the block reloads that register's seed.

Top module: `gold_chip_timing`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the outputs are: strobe = 4'b0001, sel = 4'b0000, sync = 0, and chip taken from the seed states of R2 and R3.
- R2: The frame register A steps as next = {s[4:0], s[5]^s[4]} from seed 6'b000001. On the 52nd state it reloads the seed instead of stepping, so its period is 52 enabled cycles. The frame phase is the number of enabled cycles since A last held its seed (0..51).
- R3: The code register B uses the same step rule from seed 6'b101101. It cycles through all 63 non-zero states.
- R4: chip[k] = A[5] XOR B[k] for k = 0..3. Over one code period of 3276 cycles, each pair of channels differs on at least one cycle.
- R5: strobe[k] is high exactly when the frame phase equals 13·k.
- R6: sel[k] resets to 0. It toggles on each enabled clock edge that ends a cycle with strobe[k] high, and at no other time.
- R7: At each enabled edge that ends frame phase 51, sync takes the value 1 if B is at its 63rd state (the state before its seed) in that same cycle, and 0 otherwise. Sync therefore first rises 3276 enabled cycles after reset, stays high for 52 cycles, and repeats every 3276 cycles.
- R8: While en is low, chip, strobe, sel and sync all hold their values.
- R9: At most one strobe bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one chip per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advances all state when high |
| chip | output | 4 | Per-channel Gold-code chip (1 means +1) |
| strobe | output | 4 | Per-channel track-and-hold sample strobe |
| sel | output | 4 | Per-channel integrator ping-pong select |
| sync | output | 1 | Frame-long marker once per code period |

## Verification
A wrong step rule or seed in either register shows up on chip within one cycle. A wrong truncation point in A moves the strobe pattern by the end of the first 52-cycle frame. A wrong stagger or a wrong select toggle appears on strobe or sel within that same frame. An error in the sync retiming stays hidden until cycle 3276, when the first code-period boundary either raises sync or fails to. For that reason the run extends past two full code periods, and it includes a pause on en in between.

// File: rtl/gcg_pkg.sv
package gcg_pkg;
  parameter int LFSR_W  = 6;
  parameter int TAP_HI  = 5;
  parameter int TAP_LO  = 4;
  parameter int N_CH    = 4;

  typedef logic [LFSR_W-1:0] lfsr_t;

  // one step of the shared recurrence
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  // advance a state n steps (elaboration-time constants)
  function automatic lfsr_t lfsr_adv(input lfsr_t s, input int n);
    lfsr_t t;
    t = s;
    for (int i = 0; i < n; i++) t = lfsr_step(t);
    return t;
  endfunction
endpackage

// File: rtl/gcg_lfsr.sv
module gcg_lfsr
  import gcg_pkg::*;
#(
  parameter lfsr_t SEED   = 6'b000001,
  parameter int    PERIOD = 63
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  output lfsr_t state,
  output logic  wrap
);
  // last state of the cycle; reloading the seed from here truncates (or closes) it
  localparam lfsr_t TERM = lfsr_adv(SEED, PERIOD - 1);

  assign wrap = (state == TERM);

  always_ff @(posedge clk) begin
    if (!rst_n)              state <= SEED;
    else if (en) begin
      if (state == '0)       state <= SEED;   // escape lock-up state
      else if (wrap)         state <= SEED;
      else                   state <= lfsr_step(state);
    end
  end
endmodule

// File: rtl/gcg_timing.sv
module gcg_timing
  import gcg_pkg::*;
#(
  parameter lfsr_t SEED_A  = 6'b000001,
  parameter int    STAGGER = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  lfsr_t           a_state,
  input  logic            a_wrap,
  input  logic            b_wrap,
  output logic [N_CH-1:0] strobe,
  output logic [N_CH-1:0] sel,
  output logic            sync
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    // state of A at frame phase k*STAGGER
    localparam lfsr_t MARK = lfsr_adv(SEED_A, k * STAGGER);
    assign strobe[k] = (a_state == MARK);

    always_ff @(posedge clk) begin
      if (!rst_n)                 sel[k] <= 1'b0;
      else if (en && strobe[k])   sel[k] <= ~sel[k];
    end
  end

  // retime B's wrap onto A's frame boundary
  always_ff @(posedge clk) begin
    if (!rst_n)              sync <= 1'b0;
    else if (en && a_wrap)   sync <= b_wrap;
  end
endmodule

// File: rtl/gold_chip_timing.sv
module gold_chip_timing
  import gcg_pkg::*;
#(
  parameter lfsr_t SEED_A   = 6'b000001,
  parameter lfsr_t SEED_B   = 6'b101101,
  parameter int    FRAME    = 52,
  parameter int    STAGGER  = FRAME / N_CH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [N_CH-1:0] chip,
  output logic [N_CH-1:0] strobe,
  output logic [N_CH-1:0] sel,
  output logic            sync
);
  localparam int FULL = (1 << LFSR_W) - 1;

  lfsr_t a_state, b_state;
  logic  a_wrap, b_wrap;

  gcg_lfsr #(.SEED(SEED_A), .PERIOD(FRAME)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .en(en), .state(a_state), .wrap(a_wrap)
  );

  gcg_lfsr #(.SEED(SEED_B), .PERIOD(FULL)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .en(en), .state(b_state), .wrap(b_wrap)
  );

  // per-channel Gold combination: distinct tap of B per channel
  for (genvar k = 0; k < N_CH; k++) begin : g_chip
    assign chip[k] = a_state[LFSR_W-1] ^ b_state[k % LFSR_W];
  end

  gcg_timing #(.SEED_A(SEED_A), .STAGGER(STAGGER)) u_timing (
    .clk(clk), .rst_n(rst_n), .en(en),
    .a_state(a_state), .a_wrap(a_wrap), .b_wrap(b_wrap),
    .strobe(strobe), .sel(sel), .sync(sync)
  );
endmodule

// File: rtl/gold_chip_timing_chk.sv
module gold_chip_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] chip,
  input logic [3:0] strobe,
  input logic [3:0] sel,
  input logic       sync
);
  p_onehot_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(chip) && $stable(strobe) && $stable(sel) && $stable(sync)));

  p_sync_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync != $past(sync)) |-> strobe[0]);

  for (genvar k = 0; k < 4; k++) begin : g_sel
    p_sel_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && strobe[k]) |=> (sel[k] != $past(sel[k])));
    p_sel_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(en && strobe[k]) |=> $stable(sel[k]));
  end
endmodule

bind gold_chip_timing gold_chip_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .chip(chip),
  .strobe(strobe), .sel(sel), .sync(sync)
);

// File: tb/gold_chip_timing_bench.sv
module gold_chip_timing_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] chip, strobe, sel;
  logic sync;

  always #5 clk = ~clk;

  gold_chip_timing u_gold_chip_timing (
    .clk(clk), .rst_n(rst_n), .en(en),
    .chip(chip), .strobe(strobe), .sel(sel), .sync(sync)
  );

  typedef struct {
    logic [3:0] chip;
    logic [3:0] strobe;
    logic [3:0] sel;
    logic       sync;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [5:0] pair_seen = '0;

  // model state, from the requirements
  logic [5:0] ma, mb;
  int na, nb;
  logic [3:0] msel;
  logic msync;

  function automatic logic [5:0] nstep(input logic [5:0] s);
    return {s[4:0], s[5] ^ s[4]};
  endfunction

  function automatic exp_t cur(input string tag);
    exp_t e;
    for (int k = 0; k < 4; k++) begin
      e.chip[k]   = ma[5] ^ mb[k];
      e.strobe[k] = (na == 13 * k);
    end
    e.sel  = msel;
    e.sync = msync;
    e.tag  = tag;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [3:0] got, input logic [3:0] want);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got %b expected %b", req, what, got, want);
    end
  endtask

  // driver: one clock with given enable, push expected result
  task automatic step(input bit v, input string tag);
    en = v;
    @(posedge clk);
    #1;
    if (v) begin
      for (int k = 0; k < 4; k++) if (na == 13 * k) msel[k] = ~msel[k];
      if (na == 51) msync = (nb == 62);
      ma = (na == 51) ? 6'b000001 : nstep(ma);
      na = (na == 51) ? 0 : na + 1;
      mb = nstep(mb);
      nb = (nb == 62) ? 0 : nb + 1;
    end
    q.push_back(cur(tag));
    @(negedge clk);
    #1;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(chip === e.chip, "R2/R3/R4", {e.tag, " chip"}, chip, e.chip);
      check(strobe === e.strobe, "R5", {e.tag, " strobe"}, strobe, e.strobe);
      check(sel === e.sel, "R6", {e.tag, " sel"}, sel, e.sel);
      check(sync === e.sync, "R7", {e.tag, " sync"}, {3'b0, sync}, {3'b0, e.sync});
      check($countones(strobe) <= 1, "R9", "strobe onehot", strobe, 4'b0);
      pair_seen[0] |= chip[0] ^ chip[1];
      pair_seen[1] |= chip[0] ^ chip[2];
      pair_seen[2] |= chip[0] ^ chip[3];
      pair_seen[3] |= chip[1] ^ chip[2];
      pair_seen[4] |= chip[1] ^ chip[3];
      pair_seen[5] |= chip[2] ^ chip[3];
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    ma = 6'b000001; mb = 6'b101101; na = 0; nb = 0; msel = '0; msync = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    q.push_back(cur("R1 reset"));
    @(negedge clk);
    #1;
    // first code period plus margin: first sync at 3276
    for (int i = 0; i < 3400; i++) step(1'b1, "run");
    // pause: everything holds
    for (int i = 0; i < 20; i++) step(1'b0, "R8 hold");
    for (int i = 0; i < 3400; i++) step(1'b1, "run2");
    @(negedge clk);
    @(negedge clk);
    check(pair_seen == 6'h3f, "R4", "pairwise distinct", pair_seen[3:0], 4'hf);
    finish_run();
  end
endmodule